// File: doc/BRIEF.md
# Atomic Swap Memory Unit

This block is a single-port, byte-addressed memory. It serves four kinds of request: plain reads, plain writes, invalidates and atomic read-modify-writes. An atomic request is either an unconditional swap or a compare-and-swap. Both read the current contents at the address and return them to the requester. A swap then always stores its new value. A compare-and-swap stores its new value only when the old contents equal a supplied compare value.

A request carries a kind, an address, a size, write data and a compare value, and it is accepted on a valid/ready handshake. Only one request is in flight at a time. The response carries the read data and a status code, and it is presented for one cycle a fixed, parameterised number of cycles after acceptance. The storage spans a window that starts at a configurable base address, and its total size must be a whole number of pages. The storage can optionally be cleared to zero by reset. Byte lanes are little-endian, and every access must be naturally aligned.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0. With zero-clearing enabled, every location reads back as 0.
- R2: A request accepted at clock edge k produces `rsp_valid_o` = 1 for exactly one cycle, after edge k+LATENCY. `req_ready_o` is 0 after edges k through k+LATENCY-1 and 1 again from edge k+LATENCY on.
- R3: A read (kind 0) returns the 2^size bytes at the address, zero-extended and little-endian (lowest address in bits 7:0), with status 0 (OK). The size code is 0=1, 1=2, 2=4 or 3=8 bytes.
- R4: A write (kind 1) stores the low 2^size bytes of the write data at the address, leaves every other byte unchanged, and returns read data 0 with status 0.
- R5: A swap (kind 3), at any of the four sizes, returns the old contents and always stores the new value, with status 0.
- R6: A compare-and-swap (kind 4) whose old contents equal the low 2^size bytes of the compare value stores the new value, returns the old contents and gives status 0.
- R7: A compare-and-swap whose old contents differ from the compare value leaves memory unchanged, returns the old contents and gives status 2 (no match).
- R8: A compare-and-swap with size code 0 or 1 gives status 1 (error) and read data 0, and writes nothing.
- R9: A request whose address is not a multiple of 2^size gives status 1 and read data 0, and writes nothing.
- R10: A request whose bytes are not all inside [BASE_ADDR, BASE_ADDR+MEM_BYTES) gives status 1 and read data 0, and writes nothing.
- R11: An invalidate (kind 2) gives status 0 and read data 0 and leaves memory unchanged.
- R12: Kind codes 5 to 7 give status 1 and read data 0, and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle and able to accept a request |
| req_kind_i | input | 3 | 0 read, 1 write, 2 invalidate, 3 swap, 4 compare-and-swap |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Log2 of the access size in bytes |
| req_wdata_i | input | 64 | New value, in the low bytes |
| req_cmp_i | input | 64 | Compare value, in the low bytes |
| rsp_valid_o | output | 1 | Response present for one cycle |
| rsp_rdata_o | output | 64 | Old contents, zero-extended |
| rsp_status_o | output | 2 | 0 OK, 1 error, 2 no match |

## Verification
Each response is due LATENCY edges after the edge that accepts its request. The bench therefore samples on falling edges. After the accepting edge it expects ready low and no response, it expects the response on exactly the LATENCY-th falling edge, and it expects the pulse to be gone on the falling edge that follows. A byte-array reference model updates at acceptance and supplies the expected read data and status. Read-backs after every rejected, unmatched or invalidate request show through the ports that no byte changed.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_BYTES = DATA_W / 8;

  typedef enum logic [2:0] {
    KIND_READ  = 3'd0,
    KIND_WRITE = 3'd1,
    KIND_INVAL = 3'd2,
    KIND_SWAP  = 3'd3,
    KIND_CAS   = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_ERR     = 2'd1,
    ST_NOMATCH = 2'd2
  } status_e;
endpackage

// File: rtl/amu_decode.sv
module amu_decode #(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h1000,
  parameter int          MEM_BYTES = 256,
  localparam int         IDX_W     = $clog2(MEM_BYTES / amu_pkg::WORD_BYTES)
) (
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              legal_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [2:0]        byte_off_o
);
  import amu_pkg::*;

  logic [ADDR_W:0]   rel;
  logic [ADDR_W-1:0] rel_lo;
  logic              in_range, aligned, kind_known, size_ok;

  assign rel    = {1'b0, addr_i} - {1'b0, ADDR_W'(BASE_ADDR)};
  assign rel_lo = rel[ADDR_W-1:0];
  // aligned accesses never straddle the window end: MEM_BYTES is a word multiple
  assign in_range = !rel[ADDR_W] && (rel_lo < ADDR_W'(MEM_BYTES));

  always_comb begin
    unique case (size_i)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = (addr_i[0] == 1'b0);
      2'd2:    aligned = (addr_i[1:0] == 2'b00);
      default: aligned = (addr_i[2:0] == 3'b000);
    endcase
  end

  assign kind_known = (kind_i <= KIND_CAS);
  assign size_ok    = (kind_i != KIND_CAS) || size_i[1];
  assign legal_o    = in_range && aligned && kind_known && size_ok;
  assign word_idx_o = rel_lo[IDX_W+2:3];
  assign byte_off_o = rel_lo[2:0];
endmodule

// File: rtl/amu_lane.sv
module amu_lane
  import amu_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [2:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] old_o,
  output logic [DATA_W-1:0] merged_o,
  output logic              match_o
);
  logic [DATA_W-1:0] size_mask, lane_mask;
  logic [5:0]        sh;

  always_comb begin
    unique case (size_i)
      2'd0:    size_mask = 64'h0000_0000_0000_00FF;
      2'd1:    size_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    size_mask = 64'h0000_0000_FFFF_FFFF;
      default: size_mask = '1;
    endcase
  end

  assign sh        = {off_i, 3'b000};
  assign lane_mask = size_mask << sh;
  assign old_o     = (word_i >> sh) & size_mask;
  assign match_o   = (old_o == (cmp_i & size_mask));
  assign merged_o  = (word_i & ~lane_mask) | ((wdata_i << sh) & lane_mask);
endmodule

// File: rtl/amu_store.sv
module amu_store #(
  parameter int  WORDS     = 32,
  parameter bit  ZERO_INIT = 1'b1,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [amu_pkg::DATA_W-1:0] wdata_i,
  output logic [amu_pkg::DATA_W-1:0] rdata_o
);
  logic [amu_pkg::DATA_W-1:0] mem_q [WORDS];

  generate
    if (ZERO_INIT) begin : g_clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
          mem_q[idx_i] <= wdata_i;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk_i) begin
        if (we_i) mem_q[idx_i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[idx_i];

  // R4: a written word holds the merged value on the next cycle
  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/amu_timer.sv
module amu_timer #(
  parameter int  LATENCY = 3,
  localparam int CNT_W   = $clog2(LATENCY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == CNT_W'(1));
      if (start_i)             cnt_q <= CNT_W'(LATENCY);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(start_i));
  a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int          ADDR_W     = 16,
  parameter int unsigned BASE_ADDR  = 'h1000,
  parameter int          MEM_BYTES  = 256,
  parameter int          PAGE_BYTES = 64,
  parameter int          LATENCY    = 3,
  parameter bit          ZERO_INIT  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [63:0]       req_wdata_i,
  input  logic [63:0]       req_cmp_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic [1:0]        rsp_status_o
);
  import amu_pkg::*;

  localparam int WORDS = MEM_BYTES / WORD_BYTES;
  localparam int IDX_W = $clog2(WORDS);

  logic              accept, busy, legal, match, mem_we;
  logic [IDX_W-1:0]  word_idx;
  logic [2:0]        byte_off;
  logic [DATA_W-1:0] cur_word, old_val, merged;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  status_e           status_d, status_q;
  kind_e             kind;

  initial a_r1_page_multiple: assert (MEM_BYTES % PAGE_BYTES == 0);

  assign kind        = kind_e'(req_kind_i);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  amu_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES)) u_decode (
    .kind_i(req_kind_i), .addr_i(req_addr_i), .size_i(req_size_i),
    .legal_o(legal), .word_idx_o(word_idx), .byte_off_o(byte_off)
  );

  amu_store #(.WORDS(WORDS), .ZERO_INIT(ZERO_INIT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .idx_i(word_idx),
    .wdata_i(merged), .rdata_o(cur_word)
  );

  amu_lane u_lane (
    .word_i(cur_word), .off_i(byte_off), .size_i(req_size_i),
    .wdata_i(req_wdata_i), .cmp_i(req_cmp_i),
    .old_o(old_val), .merged_o(merged), .match_o(match)
  );

  amu_timer #(.LATENCY(LATENCY)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .busy_o(busy), .done_o(rsp_valid_o)
  );

  always_comb begin
    status_d = ST_OK;
    rdata_d  = '0;
    mem_we   = 1'b0;
    if (!legal) begin
      status_d = ST_ERR;
    end else begin
      unique case (kind)
        KIND_READ:  rdata_d = old_val;
        KIND_WRITE: mem_we  = accept;
        KIND_SWAP: begin
          rdata_d = old_val;
          mem_we  = accept;
        end
        KIND_CAS: begin
          rdata_d = old_val;
          mem_we  = accept && match;
          if (!match) status_d = ST_NOMATCH;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      status_q <= ST_OK;
    end else if (accept) begin
      rdata_q  <= rdata_d;
      status_q <= status_d;
    end
  end

  assign rsp_rdata_o  = rdata_q;
  assign rsp_status_o = status_q;

  a_r7_cas_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == KIND_CAS && !match) |-> !mem_we);
  a_r11_inval_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == KIND_INVAL) |-> !mem_we);
  a_r8_short_cas_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == KIND_CAS && !req_size_i[1]) |=> (rsp_status_o == ST_ERR && !u_store.we_i));
  a_r2_ready_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
endmodule

// File: tb/atomic_mem_unit_tb.sv
module atomic_mem_unit_tb;
  localparam int          ADDR_W    = 16;
  localparam int unsigned BASE      = 'h1000;
  localparam int          MEM_BYTES = 256;
  localparam int          LAT       = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [2:0]        req_kind_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_size_i = '0;
  logic [63:0]       req_wdata_i = '0, req_cmp_i = '0;
  logic              rsp_valid_o;
  logic [63:0]       rsp_rdata_o;
  logic [1:0]        rsp_status_o;

  int nvec = 0, nfail = 0;
  logic [7:0] ref_mem [MEM_BYTES];

  always #5 clk = ~clk;

  atomic_mem_unit #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .MEM_BYTES(MEM_BYTES),
                    .PAGE_BYTES(64), .LATENCY(LAT), .ZERO_INIT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_kind_i(req_kind_i), .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .req_wdata_i(req_wdata_i), .req_cmp_i(req_cmp_i), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .rsp_status_o(rsp_status_o)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // reference behaviour from the requirements; updates the byte model at acceptance
  task automatic model(input logic [2:0] k, input logic [15:0] a, input logic [1:0] s,
                       input logic [63:0] wd, input logic [63:0] cmp,
                       output logic [63:0] er, output logic [1:0] es);
    int nb = 1 << s;
    int off = int'(a) - int'(BASE);
    logic [63:0] mask = (nb == 8) ? '1 : ((64'd1 << (nb * 8)) - 64'd1);
    logic [63:0] old = '0;
    bit ok = (k <= 3'd4) && (int'(a) % nb == 0) && off >= 0 && off + nb <= MEM_BYTES
             && !(k == 3'd4 && s < 2);
    if (ok) for (int i = 0; i < nb; i++) old[i*8 +: 8] = ref_mem[off + i];
    if (!ok)                                  es = 2'd1;
    else if (k == 3'd4 && old != (cmp & mask)) es = 2'd2;
    else                                      es = 2'd0;
    er = (ok && (k == 3'd0 || k == 3'd3 || k == 3'd4)) ? old : '0;
    if (ok && (k == 3'd1 || k == 3'd3 || (k == 3'd4 && es == 2'd0)))
      for (int i = 0; i < nb; i++) ref_mem[off + i] = wd[i*8 +: 8];
  endtask

  task automatic issue(input string tag, input logic [2:0] k, input logic [15:0] a,
                       input logic [1:0] s, input logic [63:0] wd, input logic [63:0] cmp);
    logic [63:0] er;
    logic [1:0]  es;
    @(negedge clk);
    check("R2", "idle valid", {63'd0, rsp_valid_o}, 64'd0);
    check("R2", "idle ready", {63'd0, req_ready_o}, 64'd1);
    req_valid_i = 1'b1; req_kind_i = k; req_addr_i = a; req_size_i = s;
    req_wdata_i = wd; req_cmp_i = cmp;
    model(k, a, s, wd, cmp, er, es);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R2", "busy ready", {63'd0, req_ready_o}, 64'd0);
    check("R2", "early valid", {63'd0, rsp_valid_o}, 64'd0);
    for (int j = 1; j <= LAT; j++) begin
      @(negedge clk);
      if (j < LAT) begin
        check("R2", "early valid", {63'd0, rsp_valid_o}, 64'd0);
        check("R2", "busy ready", {63'd0, req_ready_o}, 64'd0);
      end else begin
        check("R2", "due valid", {63'd0, rsp_valid_o}, 64'd1);
        check(tag, "rdata", rsp_rdata_o, er);
        check(tag, "status", {62'd0, rsp_status_o}, {62'd0, es});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "reset ready", {63'd0, req_ready_o}, 64'd1);
    check("R1", "reset valid", {63'd0, rsp_valid_o}, 64'd0);
    issue("R1", 3'd0, 16'h1000, 2'd3, '0, '0);
    issue("R1", 3'd0, 16'h10F8, 2'd3, '0, '0);
    // R4 / R3 write then sized reads
    issue("R4", 3'd1, 16'h1000, 2'd3, 64'h1122334455667788, '0);
    issue("R3", 3'd0, 16'h1000, 2'd3, '0, '0);
    issue("R3", 3'd0, 16'h1003, 2'd0, '0, '0);
    issue("R3", 3'd0, 16'h1006, 2'd1, '0, '0);
    issue("R3", 3'd0, 16'h1004, 2'd2, '0, '0);
    issue("R4", 3'd1, 16'h1001, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, '0);
    issue("R4", 3'd0, 16'h1000, 2'd3, '0, '0);
    // R5 swap
    issue("R5", 3'd3, 16'h1008, 2'd2, 64'hDEADBEEF, '0);
    issue("R5", 3'd3, 16'h1008, 2'd2, 64'h0BADF00D, '0);
    issue("R5", 3'd3, 16'h100F, 2'd0, 64'h5A, '0);
    issue("R5", 3'd0, 16'h1008, 2'd3, '0, '0);
    // R6 / R7 compare-and-swap
    issue("R6", 3'd4, 16'h1008, 2'd2, 64'hCAFEF00D, 64'hFFFF_FFFF_0BAD_F00D);
    issue("R6", 3'd0, 16'h1008, 2'd2, '0, '0);
    issue("R7", 3'd4, 16'h1008, 2'd2, 64'h12345678, 64'h0BADF00D);
    issue("R7", 3'd0, 16'h1008, 2'd2, '0, '0);
    issue("R6", 3'd4, 16'h1000, 2'd3, 64'h0123456789ABCDEF, 64'h112233445566AB88);
    issue("R7", 3'd4, 16'h1000, 2'd3, 64'h0, 64'h1);
    issue("R7", 3'd0, 16'h1000, 2'd3, '0, '0);
    // R8 short compare-and-swap
    issue("R8", 3'd4, 16'h1000, 2'd1, 64'hAAAA, 64'hCDEF);
    issue("R8", 3'd4, 16'h1000, 2'd0, 64'hAA, 64'hEF);
    issue("R8", 3'd0, 16'h1000, 2'd3, '0, '0);
    // R9 misaligned
    issue("R9", 3'd1, 16'h1002, 2'd2, 64'hFFFFFFFF, '0);
    issue("R9", 3'd3, 16'h1004, 2'd3, '1, '0);
    issue("R9", 3'd0, 16'h1000, 2'd3, '0, '0);
    // R10 window edges
    issue("R10", 3'd1, 16'h0FF8, 2'd3, '1, '0);
    issue("R10", 3'd1, 16'h1100, 2'd3, '1, '0);
    issue("R10", 3'd1, 16'h0FFF, 2'd0, '1, '0);
    issue("R10", 3'd1, 16'h10F8, 2'd3, 64'h0F0E0D0C0B0A0908, '0);
    issue("R10", 3'd0, 16'h10F8, 2'd3, '0, '0);
    issue("R10", 3'd0, 16'h10FF, 2'd0, '0, '0);
    // R11 invalidate
    issue("R11", 3'd2, 16'h1000, 2'd3, '1, '0);
    issue("R11", 3'd0, 16'h1000, 2'd3, '0, '0);
    // R12 unknown kinds
    issue("R12", 3'd5, 16'h1000, 2'd3, '1, '0);
    issue("R12", 3'd7, 16'h1010, 2'd2, '1, '0);
    issue("R12", 3'd0, 16'h1000, 2'd3, '0, '0);
    // mixed traffic against the model
    for (int n = 0; n < 300; n++) begin
      logic [2:0]  k = 3'($urandom % 8);
      logic [1:0]  s = 2'($urandom % 4);
      logic [15:0] a = 16'(BASE - 8 + ($urandom % (MEM_BYTES + 16)));
      logic [63:0] wd = {$urandom, $urandom};
      logic [63:0] cm = ($urandom % 2 == 0) ? {$urandom, $urandom} : '0;
      if (k < 3'd5 && $urandom % 3 == 0) a[2:0] = 3'b000;
      issue("R7", k, a, s, wd, cm);
    end
    @(negedge clk);
    check("R2", "final valid", {63'd0, rsp_valid_o}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule